// File: doc/BRIEF.md
# Reference-Counted Power Clamp Sequencer

This block drives the isolation controls of a pad/PHY power domain: a core-supply-down request, an early clamp and a main clamp, all active high, plus a PHY reset that is also active high. Any number of clients share the domain. Each client sends a one-cycle enable pulse when it needs the domain and a one-cycle disable pulse when it is done. A use counter tracks the clients. Only the first enable and the last disable change the outputs. Every other request just moves the count.

A transition is a timed, four-step sequence with `STEP_CYCLES` clock cycles between steps. The first step happens on the clock edge that accepts the request. Power-up releases the main clamp, then the early clamp, then the core-supply-down request, and last the PHY reset. Power-down runs the same steps in reverse: it asserts the PHY reset, then core-supply-down, then the early clamp, then the main clamp. `busy` is high while a sequence runs. A request that arrives during a sequence waits in a one-deep slot and is acted on after the sequence ends. `fault` pulses when a request is refused.

Top module: `pwr_clamp_seq`

## Requirements
- R1: After a synchronous active-low reset, `core_down`, `clamp_early`, `clamp_main` and `phy_rst` are all 1, `busy` and `fault` are 0, and the use count is zero.
- R2: An enable accepted while the count is zero starts power-up. On the accepting edge `clamp_main` falls. `clamp_early` falls STEP_CYCLES cycles later, `core_down` falls 2*STEP_CYCLES cycles later, and `phy_rst` falls 3*STEP_CYCLES cycles later.
- R3: A disable accepted while the count is one starts power-down. On the accepting edge `phy_rst` rises. `core_down` rises STEP_CYCLES cycles later, `clamp_early` rises 2*STEP_CYCLES cycles later, and `clamp_main` rises 3*STEP_CYCLES cycles later.
- R4: An enable accepted while the count is between 1 and the maximum minus one adds one to the count. No output changes and `busy` stays low.
- R5: A disable accepted while the count is greater than one subtracts one from the count. No output changes and `busy` stays low.
- R6: A disable accepted while the count is zero raises `fault` for exactly one cycle. The count and the outputs do not change.
- R7: `busy` rises on the accepting edge of a power-up or power-down and falls on the edge of the fourth step. That makes it high for 3*STEP_CYCLES cycles.
- R8: A request that arrives while `busy` is high is kept in a one-deep slot and handled on the first edge after `busy` falls. Further requests that arrive while the slot is full are dropped. When an incoming request arrives on the same edge that the slot is handled, the incoming request takes the freed slot.
- R9: If `en_pulse` and `dis_pulse` are high in the same cycle, the request is taken as an enable and the disable is dropped.
- R10: An enable accepted while the count is at its maximum (2^CNT_W - 1) raises `fault` for one cycle. The count and the outputs do not change.
- R11: The outputs are always ordered: `clamp_main` implies `clamp_early`, `clamp_early` implies `core_down`, and `core_down` implies `phy_rst`. While `busy` is low, the four outputs are either all 1 or all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pulse | input | 1 | One-cycle enable request from a client |
| dis_pulse | input | 1 | One-cycle disable request from a client |
| busy | output | 1 | A power-up or power-down sequence is in progress |
| fault | output | 1 | One-cycle pulse: a request was refused (count underflow or overflow) |
| core_down | output | 1 | Core-supply-down request, active high |
| clamp_early | output | 1 | Early clamp, active high |
| clamp_main | output | 1 | Main clamp, active high |
| phy_rst | output | 1 | PHY reset, active high |

## Verification
The block is driven with the following request patterns, and each one shows a different behaviour:
- A lone enable on an idle domain and a final disable separate the two opposite step orders and their timing.
- Back-to-back enables and disables on a domain that is already up show that the count moves while the outputs stay still.
- A disable on an idle domain and an enable at the full count show the two refusal cases.
- Requests sent in the middle of a sequence show what the pending slot holds and what it drops.
- A simultaneous enable and disable shows the tie rule.

A behavioural model in the bench follows the count, the slot and the elapsed time of each sequence. It is compared with every output on every cycle, and a separate check tests the output ordering rule.

// File: rtl/pwr_clamp_pkg.sv
// Package: shared request encoding for the power clamp sequencer.
// Assumes: nothing beyond SystemVerilog 2017.
package pwr_clamp_pkg;
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_ON   = 2'd1,
        REQ_OFF  = 2'd2
    } req_e;

    localparam int NUM_STEPS = 4;
endpackage

// File: rtl/pwr_req_slot.sv
// Module: pwr_req_slot
// Picks the request to act on this cycle and keeps one request that arrives
// during a sequence. Enable wins over a simultaneous disable.
// Assumes: busy_i is the registered sequencer busy flag.
module pwr_req_slot
    import pwr_clamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    input  logic off_i,
    input  logic busy_i,
    output req_e take_o
);
    req_e incoming;
    req_e pend_q;

    // Decode the raw pulses; enable has priority (R9)
    always_comb begin
        if (on_i)       incoming = REQ_ON;
        else if (off_i) incoming = REQ_OFF;
        else            incoming = REQ_NONE;
    end

    // Offer the held request first when idle, otherwise the incoming one
    always_comb begin
        if (busy_i)                take_o = REQ_NONE;
        else if (pend_q != REQ_NONE) take_o = pend_q;
        else                       take_o = incoming;
    end

    // Fill the slot while busy; refill it from the incoming pulse when it is drained
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= REQ_NONE;
        end else if (busy_i) begin
            if (pend_q == REQ_NONE) pend_q <= incoming;
        end else if (pend_q != REQ_NONE) begin
            pend_q <= incoming;
        end
    end

    // R8
    slot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && pend_q != REQ_NONE) |=> (pend_q == $past(pend_q)));
endmodule

// File: rtl/pwr_use_count.sv
// Module: pwr_use_count
// Tracks how many clients hold the domain and decides whether an accepted
// request starts a sequence, only moves the count, or is refused.
// Assumes: take_i is non-NONE only while the sequencer is idle.
module pwr_use_count
    import pwr_clamp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  req_e take_i,
    output logic start_up_o,
    output logic start_dn_o,
    output logic fault_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Only the 0->1 and 1->0 transitions start a sequence
    always_comb begin
        start_up_o = (take_i == REQ_ON)  && (cnt_q == '0);
        start_dn_o = (take_i == REQ_OFF) && (cnt_q == CNT_ONE);
    end

    // Update the count and flag refused requests for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fault_o <= 1'b0;
        end else begin
            fault_o <= 1'b0;
            if (take_i == REQ_ON) begin
                if (cnt_q == CNT_MAX) fault_o <= 1'b1;
                else                  cnt_q   <= cnt_q + CNT_ONE;
            end else if (take_i == REQ_OFF) begin
                if (cnt_q == '0) fault_o <= 1'b1;
                else             cnt_q   <= cnt_q - CNT_ONE;
            end
        end
    end

    // R4
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i == REQ_ON && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
    // R6
    cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i == REQ_OFF && cnt_q == '0) |=> (fault_o && cnt_q == '0));
    // R10
    cnt_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i == REQ_ON && cnt_q == CNT_MAX) |=> (fault_o && cnt_q == CNT_MAX));
endmodule

// File: rtl/pwr_step_seq.sv
// Module: pwr_step_seq
// Runs the four-step timed sequence on the isolation outputs. Step k of a
// sequence lands k*STEP_CYCLES cycles after the start edge.
// Assumes: a start arrives only while busy_o is low; STEP_CYCLES >= 1.
module pwr_step_seq
    import pwr_clamp_pkg::*;
#(
    parameter int STEP_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_up_i,
    input  logic start_dn_i,
    output logic busy_o,
    output logic core_down_o,
    output logic clamp_early_o,
    output logic clamp_main_o,
    output logic phy_rst_o
);
    localparam int TW = (STEP_CYCLES < 2) ? 1 : $clog2(STEP_CYCLES);
    localparam logic [TW-1:0] T_RELOAD = TW'(STEP_CYCLES - 1);
    localparam int PW = $clog2(NUM_STEPS);
    localparam logic [PW-1:0] P_LAST = PW'(NUM_STEPS - 1);

    // Bit order: 0 main clamp, 1 early clamp, 2 core down, 3 PHY reset
    logic [NUM_STEPS-1:0] lvl_q;
    logic [TW-1:0]        tmr_q;
    logic [PW-1:0]        phase_q;
    logic                 up_q;

    // Select the output touched by a phase: up goes 0..3, down goes 3..0
    function automatic logic [PW-1:0] step_bit(input logic up, input logic [PW-1:0] ph);
        return up ? ph : (P_LAST - ph);
    endfunction

    // Start a sequence, wait out each step and apply the next output change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= '1;
            tmr_q   <= '0;
            phase_q <= '0;
            up_q    <= 1'b0;
            busy_o  <= 1'b0;
        end else if (start_up_i || start_dn_i) begin
            up_q    <= start_up_i;
            lvl_q[step_bit(start_up_i, '0)] <= ~start_up_i;
            phase_q <= PW'(1);
            tmr_q   <= T_RELOAD;
            busy_o  <= 1'b1;
        end else if (busy_o) begin
            if (tmr_q == '0) begin
                lvl_q[step_bit(up_q, phase_q)] <= ~up_q;
                if (phase_q == P_LAST) begin
                    busy_o <= 1'b0;
                end else begin
                    phase_q <= phase_q + PW'(1);
                    tmr_q   <= T_RELOAD;
                end
            end else begin
                tmr_q <= tmr_q - TW'(1);
            end
        end
    end

    assign clamp_main_o  = lvl_q[0];
    assign clamp_early_o = lvl_q[1];
    assign core_down_o   = lvl_q[2];
    assign phy_rst_o     = lvl_q[3];

    // R11
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_q[0] || lvl_q[1]) && (!lvl_q[1] || lvl_q[2]) && (!lvl_q[2] || lvl_q[3]));
    // R11
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (lvl_q == '0 || lvl_q == '1));
    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_up_i || start_dn_i) |-> !busy_o);
    // R7
    busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/pwr_clamp_seq.sv
// Module: pwr_clamp_seq (top)
// Reference-counted power clamp sequencer: joins the request slot, the use
// counter and the step sequencer.
// Assumes: en_pulse/dis_pulse are synchronous to clk; reset is synchronous.
module pwr_clamp_seq
    import pwr_clamp_pkg::*;
#(
    parameter int STEP_CYCLES = 10000,
    parameter int CNT_W       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pulse,
    input  logic dis_pulse,
    output logic busy,
    output logic fault,
    output logic core_down,
    output logic clamp_early,
    output logic clamp_main,
    output logic phy_rst
);
    req_e take;
    logic start_up;
    logic start_dn;

    pwr_req_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .on_i   (en_pulse),
        .off_i  (dis_pulse),
        .busy_i (busy),
        .take_o (take)
    );

    pwr_use_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .start_up_o (start_up),
        .start_dn_o (start_dn),
        .fault_o    (fault)
    );

    pwr_step_seq #(.STEP_CYCLES(STEP_CYCLES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_up_i    (start_up),
        .start_dn_i    (start_dn),
        .busy_o        (busy),
        .core_down_o   (core_down),
        .clamp_early_o (clamp_early),
        .clamp_main_o  (clamp_main),
        .phy_rst_o     (phy_rst)
    );

    // R6
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable({core_down, clamp_early, clamp_main, phy_rst}));
endmodule

// File: tb/pwr_clamp_seq_bench.sv
// Bench for pwr_clamp_seq: a behavioural model is compared on every cycle.
module pwr_clamp_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STEP = 5;
    localparam int CW = 4;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pulse = 1'b0;
    logic dis_pulse = 1'b0;
    logic busy, fault, core_down, clamp_early, clamp_main, phy_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_clamp_seq #(.STEP_CYCLES(STEP), .CNT_W(CW)) u_pwr_clamp_seq (
        .clk(clk), .rst_n(rst_n), .en_pulse(en_pulse), .dis_pulse(dis_pulse),
        .busy(busy), .fault(fault), .core_down(core_down),
        .clamp_early(clamp_early), .clamp_main(clamp_main), .phy_rst(phy_rst)
    );

    // Model state: 0 none, 1 enable, 2 disable
    int m_cnt = 0;
    int m_pend = 0;
    bit m_act = 0;
    bit m_up = 0;
    int m_t = 0;
    bit m_busy = 0;
    bit m_fault = 0;
    bit [3:0] m_lvl = 4'hF;  // 0 main, 1 early, 2 core, 3 phy

    always @(posedge clk) begin
        int inc;
        int take;
        bit go_up;
        bit go_dn;
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_pend = 0; m_act = 0; m_t = 0;
            m_busy = 0; m_fault = 0; m_lvl = 4'hF;
        end else begin
            inc = en_pulse ? 1 : (dis_pulse ? 2 : 0);
            take = 0; go_up = 0; go_dn = 0;
            m_fault = 0;
            if (m_busy) begin
                if (m_pend == 0) m_pend = inc;
            end else if (m_pend != 0) begin
                take = m_pend;
                m_pend = inc;
            end else begin
                take = inc;
            end
            if (take == 1) begin
                if (m_cnt == MAXC) m_fault = 1;
                else begin
                    if (m_cnt == 0) go_up = 1;
                    m_cnt++;
                end
            end else if (take == 2) begin
                if (m_cnt == 0) m_fault = 1;
                else begin
                    if (m_cnt == 1) go_dn = 1;
                    m_cnt--;
                end
            end
            if (m_act) m_t++;
            if (go_up || go_dn) begin
                m_act = 1; m_up = go_up; m_t = 0;
            end
            if (m_act) begin
                for (int k = 0; k < 4; k++)
                    if (m_t >= k * STEP) m_lvl[m_up ? k : 3 - k] = ~m_up;
                m_busy = (m_t < 3 * STEP);
                if (m_t >= 3 * STEP) m_act = 0;
            end else begin
                m_busy = 0;
            end
        end
    end

    task automatic check1(input string req, input string sig, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", req, sig, act, exp, cycles);
        end
    endtask

    // Compare all outputs with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n || cycles > 2) begin
            check1("R7", "busy", busy, m_busy);
            check1(tag, "fault", fault, m_fault);
            check1(tag, "clamp_main", clamp_main, m_lvl[0]);
            check1(tag, "clamp_early", clamp_early, m_lvl[1]);
            check1(tag, "core_down", core_down, m_lvl[2]);
            check1(tag, "phy_rst", phy_rst, m_lvl[3]);
            check1("R11", "ordering", (!clamp_main || clamp_early) && (!clamp_early || core_down)
                   && (!core_down || phy_rst), 1'b1);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit e, input bit d);
        @(negedge clk);
        en_pulse = e; dis_pulse = d;
        @(negedge clk);
        en_pulse = 0; dis_pulse = 0;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tag = "R1";
        idle(3);
        rst_n = 1;
        idle(3);
        tag = "R2"; pulse(1, 0); idle(4 * STEP);
        tag = "R4"; pulse(1, 0); idle(3); pulse(1, 0); idle(3);
        tag = "R5"; pulse(0, 1); idle(3); pulse(0, 1); idle(3);
        tag = "R3"; pulse(0, 1); idle(4 * STEP);
        tag = "R6"; pulse(0, 1); idle(3);
        tag = "R8";
        pulse(1, 0); idle(1); pulse(1, 0); idle(1); pulse(0, 1); idle(5 * STEP);
        pulse(0, 1); idle(2); pulse(0, 1); idle(1); pulse(1, 0); idle(8 * STEP);
        pulse(0, 1); idle(4 * STEP);
        tag = "R9"; pulse(1, 1); idle(4 * STEP); pulse(0, 1); idle(4 * STEP);
        tag = "R10";
        pulse(1, 0); idle(4 * STEP);
        for (int i = 0; i < MAXC - 1; i++) pulse(1, 0);
        idle(2);
        pulse(1, 0); idle(3);
        tag = "R11";
        for (int i = 0; i < MAXC; i++) pulse(0, 1);
        idle(4 * STEP);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule